// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block does signed saturating arithmetic on two-operand words. Each cycle it takes a pair of signed operands and a 2-bit operation code. It produces the clamped result one clock later. There are four operations: plain add, plain subtract, and doubling forms of each. In a doubling form, the second operand is first multiplied by two with saturation, and the result is then combined with the first operand, saturating a second time.

A sticky saturation indicator records that a clamp took place. Either saturation step can set it. It stays set until software-side logic pulses a dedicated clear input. Downstream signal-processing code can therefore run a long stretch of arithmetic and then ask a single question: did anything clip?

Top module: `sat_arith_unit`

## Requirements
- R1: With op code 2'b00, the result is the signed sum a+b, clamped to the representable range.
- R2: With op code 2'b01, the result is the signed difference a-b, clamped to the representable range.
- R3: With op code 2'b10, b is first doubled with clamping, and the result is a plus that doubled value, clamped again.
- R4: With op code 2'b11, b is first doubled with clamping, and the result is a minus that doubled value, clamped again.
- R5: A value that is too large clamps to 32'h7FFF_FFFF. A value that is too small clamps to 32'h8000_0000. This holds for both the doubling step and the final step.
- R6: The result for the inputs present before a rising clock edge appears on the output after that edge, and not before.
- R7: The sticky flag becomes 1 after any edge at which a saturation step clamped. This includes the case where only the doubling step clamped.
- R8: Once set, the sticky flag stays 1 through any number of non-clamping operations while the clear input is low.
- R9: When clear is high at an edge, the flag becomes 0 unless an operation clamps at that same edge, in which case the flag is 1.
- R10: Synchronous active-high reset drives the result to 0 and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | First signed operand |
| b_i | input | 32 | Second signed operand (the doubled one) |
| op_i | input | 2 | 00 add, 01 sub, 10 doubling add, 11 doubling sub |
| clr_sat_i | input | 1 | Clears the sticky flag |
| result_o | output | 32 | Registered saturated result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a clamp in the doubling step that the final step does not hide. Here b's magnitude exceeds half the range, but a pulls the sum back into range, so the output looks ordinary while the flag must still rise. The bench reaches it with a corner-value sweep whose operands include the quarter-range boundaries and their neighbours, so that every operation sees clamp-in-first-step-only, clamp-in-second-step-only and both. It then adds directed sequences where the flag is cleared between vectors and a clear coincides with a clamp.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

    typedef struct packed {
        logic dbl_clamp;
        logic fin_clamp;
    } clamp_info_t;

    function automatic logic op_doubles(input sat_op_e op);
        return op[1];
    endfunction

    function automatic logic op_subtracts(input sat_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dbl_o,
    output logic         clamped_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        clamped_o = val_i[W-1] ^ val_i[W-2];
        if (clamped_o)
            dbl_o = val_i[W-1] ? MINV : MAXV;
        else
            dbl_o = {val_i[W-2:0], 1'b0};
    end

    // R3: doubling never changes the sign of the operand
    always_comb begin
        p_dbl_sign_r3: assert (dbl_o[W-1] == val_i[W-1]);
        if (!clamped_o)
            p_dbl_exact_r3: assert (dbl_o == val_i + val_i);
    end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         clamped_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_l, ext_r, wide;

    always_comb begin
        ext_l     = {lhs_i[W-1], lhs_i};
        ext_r     = {rhs_i[W-1], rhs_i};
        wide      = sub_i ? (ext_l - ext_r) : (ext_l + ext_r);
        clamped_o = wide[W] ^ wide[W-1];
        if (clamped_o)
            res_o = wide[W] ? MINV : MAXV;
        else
            res_o = wide[W-1:0];
    end

    always_comb begin
        // R1 and R2: an in-range result equals the wrapped arithmetic value
        if (!clamped_o)
            p_inrange_exact_r1: assert (res_o == (sub_i ? lhs_i - rhs_i : lhs_i + rhs_i));
        // R5: a clamped result is one of the two extremes
        if (clamped_o)
            p_clamp_extreme_r5: assert (res_o == MAXV || res_o == MINV);
    end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [31:0]  a_i,
    input  logic [31:0]  b_i,
    input  logic [1:0]   op_i,
    input  logic         clr_sat_i,
    output logic [31:0]  result_o,
    output logic         sat_o
);
    localparam int OW = 32;

    sat_op_e     op;
    clamp_info_t clamps;
    logic [OW-1:0] dbl_b, rhs, comb_res;
    logic          any_clamp;

    assign op = sat_op_e'(op_i);

    sat_doubler #(.W(OW)) u_dbl (
        .val_i     (b_i),
        .dbl_o     (dbl_b),
        .clamped_o (clamps.dbl_clamp)
    );

    assign rhs = op_doubles(op) ? dbl_b : b_i;

    sat_addsub #(.W(OW)) u_addsub (
        .lhs_i     (a_i),
        .rhs_i     (rhs),
        .sub_i     (op_subtracts(op)),
        .res_o     (comb_res),
        .clamped_o (clamps.fin_clamp)
    );

    assign any_clamp = clamps.fin_clamp | (op_doubles(op) & clamps.dbl_clamp);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            sat_o    <= 1'b0;
        end else begin
            result_o <= comb_res;
            sat_o    <= (sat_o & ~clr_sat_i) | any_clamp;
        end
    end

    // R7: any clamp sets the flag at the next edge
    p_clamp_sets_r7: assert property (@(posedge clk) disable iff (rst)
        any_clamp |=> sat_o);
    // R8: a set flag holds while clear is low
    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (sat_o && !clr_sat_i) |=> sat_o);
    // R9: clear without a clamp empties the flag
    p_clear_works_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_sat_i && !any_clamp) |=> !sat_o);
    // R1: registered non-clamping add equals the operand sum
    p_add_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && !any_clamp) |=> (result_o == $past(a_i) + $past(b_i)));
    // R10: reset leaves result and flag at zero
    p_reset_zero_r10: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !sat_o));
endmodule

// File: tb/test_sat_arith_unit.sv
`timescale 1ns/1ps
module test_sat_arith_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] a, b;
    logic [1:0]  op;
    logic        clr;
    logic [31:0] result;
    logic        sat;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_flag = 1'b0;

    always #5 clk = ~clk;

    sat_arith_unit i_sat_arith_unit (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op),
        .clr_sat_i(clr), .result_o(result), .sat_o(sat)
    );

    // R5 clamp bounds computed arithmetically
    function automatic logic [31:0] clamp32(input longint v, output logic hit);
        hit = 1'b0;
        if (v > 64'sd2147483647) begin hit = 1'b1; return 32'h7FFF_FFFF; end
        if (v < -64'sd2147483648) begin hit = 1'b1; return 32'h8000_0000; end
        return v[31:0];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] o, output logic hit);
        longint sx, sy, t;
        logic h1, h2;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        h1 = 1'b0;
        if (o[1]) begin
            t  = 2 * sy;
            sy = longint'($signed(clamp32(t, h1)));
        end
        t = o[0] ? sx - sy : sx + sy;
        model = clamp32(t, h2);
        hit = h1 | h2;
    endfunction

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic cond, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] y,
                         input logic [1:0] o, input logic c, input string ftag);
        logic [31:0] er;
        logic hit;
        @(negedge clk);
        a = x; b = y; op = o; clr = c;
        er = model(x, y, o, hit);
        exp_flag = (exp_flag & ~c) | hit;
        @(negedge clk);
        check(result === er, op_tag(o), result, er);
        check(sat === exp_flag, ftag, {31'd0, sat}, {31'd0, exp_flag});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] corners [12];
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                    32'h7FFF_FFFE, 32'h8000_0001, 32'h4000_0000, 32'hC000_0000,
                    32'h3FFF_FFFF, 32'hBFFF_FFFF, 32'h1234_5678};
        rst = 1'b1; a = 32'hDEAD_BEEF; b = 32'h7FFF_FFFF; op = 2'b00; clr = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state despite clamping inputs
        check(result === 32'h0, "R10", result, 32'h0);
        check(sat === 1'b0, "R10", {31'd0, sat}, 32'h0);
        rst = 1'b0;

        // R6: output unchanged before the edge, updated after it
        apply(32'd5, 32'd7, 2'b00, 1'b0, "R8");
        @(negedge clk);
        a = 32'd100; b = 32'd1; op = 2'b01;
        #1 check(result === 32'd12, "R6", result, 32'd12);
        @(negedge clk);
        check(result === 32'd99, "R6", result, 32'd99);

        // R7: only the doubling step clamps (R3): -1 + sat(2*0x40000000)
        apply(32'hFFFF_FFFF, 32'h4000_0000, 2'b10, 1'b0, "R7");
        check(result === 32'h7FFF_FFFE, "R7", result, 32'h7FFF_FFFE);
        // R8: non-clamping ops keep the flag
        apply(32'd1, 32'd2, 2'b00, 1'b0, "R8");
        apply(32'd9, 32'd3, 2'b11, 1'b0, "R8");
        // R9: clear without clamp, then clear with clamp
        apply(32'd1, 32'd1, 2'b00, 1'b1, "R9");
        apply(32'h7FFF_FFFF, 32'd1, 2'b00, 1'b1, "R9");
        apply(32'd0, 32'd0, 2'b00, 1'b1, "R9");

        // Corner sweep across all ops, R1..R5
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply(corners[i], corners[j], o[1:0], (j == 0), "R7");

        // Pseudo-random spread
        for (int k = 0; k < 400; k++)
            apply($urandom, $urandom, k[1:0], (k % 7 == 0), "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule